// File: doc/BRIEF.md
# Vector Unpack Format Expander

This block takes a stream of packed bytes and expands each group of bytes into one 128-bit quadword made of four 32-bit lanes. A 4-bit format code picks the element width (32, 16 or 8 bits) and the number of components (one to four). One extra code selects a packed 16-bit colour format. For the narrow formats, a flag chooses between zero extension and sign extension. Bytes arrive one per cycle on a valid/ready handshake. Quadwords leave on a second valid/ready handshake.

A 2-bit combine mode can add a bank of four row registers to the expanded lanes. In accumulate mode each sum is also written back into its row register, so a running total carries from one quadword to the next. The row bank is loaded through a dedicated load strobe.

The control is a four-state machine:
- **IDLE** waits for `in_valid`. It then latches the configuration and moves to **COLLECT**, or moves to **FAULT** if the code is invalid.
- **COLLECT** accepts bytes until the group is complete, then moves to **EMIT**.
- **EMIT** presents the quadword until `out_ready`, then returns to **IDLE**.
- **FAULT** raises `err` and returns to **IDLE** once `cfg_type` holds a valid code.

Top module: `vec_unpack`

## Requirements
- R1: Format code `cfg_type[1:0]` selects the element width: 0 is 32-bit, 1 is 16-bit, 2 is 8-bit. `cfg_type[3:2]` plus one is the component count. A group takes component count × element bytes from the stream, except code 0xF, which takes 2 bytes. The first byte received is the least significant byte of element 0, and element i goes to lane i (lane i is `out_qw[32i+31:32i]`).
- R2: A scalar format (`cfg_type[3:2]`=0) places its single expanded element in all four lanes.
- R3: For the 2- and 3-component formats in combine mode 0, the lanes above the last component are zero.
- R4: For 16-bit and 8-bit elements, `cfg_unsigned`=1 zero-extends each element to 32 bits and `cfg_unsigned`=0 sign-extends it.
- R5: The 32-bit formats and the colour format give the same result for either value of `cfg_unsigned`.
- R6: Code 0xF is the colour format. Input bits [4:0], [9:5] and [14:10] go to lanes 0, 1 and 2, each shifted left by 3. Bit 15 goes to lane 3, shifted left by 7.
- R7: Codes 0x3, 0x7 and 0xB are invalid. In IDLE with `in_valid` high, such a code sets `err` on the next cycle. While `err` is high, no byte is accepted and no quadword is produced. `err` clears one cycle after `cfg_type` shows a valid code.
- R8: In combine mode 1 each lane outputs the expanded value plus its row register, and the row registers are left unchanged.
- R9: In combine mode 2 each lane outputs the expanded value plus its row register. On each completed output handshake, that sum is written back into the row register.
- R10: Combine modes 0 and 3 output the expanded value without the row registers.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_qw` holds its value.
- R12: A pulse on `row_load` copies `row_wdata` into the row bank, with lane i of the bank taken from `row_wdata[32i+31:32i]`.
- R13: After reset, `in_ready`, `out_valid` and `err` are low and all row registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_type | input | 4 | Unpack format code |
| cfg_unsigned | input | 1 | 1 = zero-extend narrow elements, 0 = sign-extend |
| cfg_mode | input | 2 | Row combine mode |
| row_load | input | 1 | Load strobe for the row registers |
| row_wdata | input | 128 | Row register load value |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted |
| out_valid | output | 1 | Quadword valid |
| out_ready | input | 1 | Quadword accepted downstream |
| out_qw | output | 128 | Expanded quadword |
| err | output | 1 | Invalid format code seen |

## Verification
`in_ready` rises one cycle after `in_valid` is seen in IDLE. `out_valid` rises on the edge that accepts the last byte of a group. `err` rises one cycle after an invalid code meets `in_valid`. A row write-back is visible on the edge that completes the output handshake. The bench drives and samples only on falling edges. It polls `in_ready` and `out_valid` there instead of assuming fixed latencies. Each quadword is captured in the same half-cycle that `out_valid` is first seen. Row effects are checked through the next quadword's lanes.

// File: rtl/vux_pkg.sv
package vux_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_EMIT,
        ST_FAULT
    } vux_state_e;

    localparam logic [3:0] TYPE_COLOUR = 4'hF;
    localparam logic [1:0] MODE_OFFSET = 2'd1;
    localparam logic [1:0] MODE_ACCUM  = 2'd2;

    function automatic logic type_bad(input logic [3:0] t);
        return (t[1:0] == 2'd3) && (t != TYPE_COLOUR);
    endfunction

    function automatic logic [4:0] group_bytes(input logic [3:0] t);
        logic [4:0] w;
        if (t == TYPE_COLOUR) return 5'd2;
        w = (t[1:0] == 2'd0) ? 5'd4 : (t[1:0] == 2'd1) ? 5'd2 : 5'd1;
        return w * ({3'b000, t[3:2]} + 5'd1);
    endfunction

    function automatic logic [31:0] colour_lane(input logic [15:0] h, input int idx);
        case (idx)
            0:       return {24'd0, h[4:0],   3'd0};
            1:       return {24'd0, h[9:5],   3'd0};
            2:       return {24'd0, h[14:10], 3'd0};
            default: return {24'd0, h[15],    7'd0};
        endcase
    endfunction

endpackage

// File: rtl/vux_ctrl.sv
module vux_ctrl
    import vux_pkg::*;
#(
    parameter int BUF_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             cfg_type,
    input  logic                   cfg_unsigned,
    input  logic [1:0]             cfg_mode,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic                   in_ready,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic                   err,
    output logic                   fire,
    output logic                   idle,
    output logic [BUF_BYTES*8-1:0] buf_o,
    output logic [3:0]             type_o,
    output logic                   usn_o,
    output logic [1:0]             mode_o
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    vux_state_e             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, need_q;
    logic [BUF_BYTES*8-1:0] buf_q;
    logic [3:0]             type_q;
    logic                   usn_q;
    logic [1:0]             mode_q;
    logic                   take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) state_d = type_bad(cfg_type) ? ST_FAULT : ST_COLLECT;
            end
            ST_COLLECT: begin
                if (take && (cnt_q + 1'b1 == need_q)) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (out_ready) state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (!type_bad(cfg_type)) state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        err       = 1'b0;
        idle      = 1'b0;
        unique case (state_q)
            ST_IDLE:    idle      = 1'b1;
            ST_COLLECT: in_ready  = 1'b1;
            ST_EMIT:    out_valid = 1'b1;
            ST_FAULT:   err       = 1'b1;
        endcase
    end

    assign take = in_valid && in_ready;
    assign fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            need_q <= '0;
            buf_q  <= '0;
            type_q <= '0;
            usn_q  <= 1'b0;
            mode_q <= '0;
        end else if (idle && in_valid) begin
            cnt_q  <= '0;
            need_q <= CNT_W'(group_bytes(cfg_type));
            buf_q  <= '0;
            type_q <= cfg_type;
            usn_q  <= cfg_unsigned;
            mode_q <= cfg_mode;
        end else if (take) begin
            buf_q[cnt_q*8 +: 8] <= in_byte;
            cnt_q               <= cnt_q + 1'b1;
        end
    end

    assign buf_o  = buf_q;
    assign type_o = type_q;
    assign usn_o  = usn_q;
    assign mode_o = mode_q;

endmodule

// File: rtl/vux_expand.sv
module vux_expand
    import vux_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 32
) (
    input  logic [LANES*LANE_W-1:0] buf_i,
    input  logic [3:0]              fmt,
    input  logic                    usn,
    output logic [LANES*LANE_W-1:0] lanes_o
);
    localparam int QW = LANES * LANE_W;

    logic [LANE_W-1:0] raw [LANES];

    for (genvar gi = 0; gi < LANES; gi++) begin : g_raw
        always_comb begin
            logic [31:0] e32;
            logic [15:0] e16;
            logic [7:0]  e8;
            e32 = buf_i[32*gi +: 32];
            e16 = buf_i[16*gi +: 16];
            e8  = buf_i[8*gi  +: 8];
            unique case (fmt[1:0])
                2'd0:    raw[gi] = e32;
                2'd1:    raw[gi] = {{16{!usn && e16[15]}}, e16};
                default: raw[gi] = {{24{!usn && e8[7]}}, e8};
            endcase
        end

        always_comb begin
            if (fmt == TYPE_COLOUR)
                lanes_o[LANE_W*gi +: LANE_W] = colour_lane(buf_i[15:0], gi);
            else if (fmt[3:2] == 2'd0)
                lanes_o[LANE_W*gi +: LANE_W] = raw[0];
            else if (gi <= int'(fmt[3:2]))
                lanes_o[LANE_W*gi +: LANE_W] = raw[gi];
            else
                lanes_o[LANE_W*gi +: LANE_W] = '0;
        end
    end

    logic unused_hi;
    assign unused_hi = ^buf_i[QW-1:QW-1];

endmodule

// File: rtl/vux_rows.sv
module vux_rows #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [LANES*LANE_W-1:0] load_data,
    input  logic                    acc_en,
    input  logic [LANES*LANE_W-1:0] acc_data,
    output logic [LANES*LANE_W-1:0] rows_o
);
    for (genvar gi = 0; gi < LANES; gi++) begin : g_row
        logic [LANE_W-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      row_q <= '0;
            else if (load)   row_q <= load_data[LANE_W*gi +: LANE_W];
            else if (acc_en) row_q <= acc_data[LANE_W*gi +: LANE_W];
        end
        assign rows_o[LANE_W*gi +: LANE_W] = row_q;
    end
endmodule

// File: rtl/vec_unpack.sv
module vec_unpack
    import vux_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              cfg_type,
    input  logic                    cfg_unsigned,
    input  logic [1:0]              cfg_mode,
    input  logic                    row_load,
    input  logic [LANES*LANE_W-1:0] row_wdata,
    input  logic                    in_valid,
    input  logic [7:0]              in_byte,
    output logic                    in_ready,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*LANE_W-1:0] out_qw,
    output logic                    err
);
    localparam int QW = LANES * LANE_W;

    logic          fire, st_idle, cur_usn;
    logic [QW-1:0] buf_w, lanes_w, row_flat;
    logic [3:0]    cur_type;
    logic [1:0]    cur_mode;
    logic          add_rows;

    vux_ctrl #(.BUF_BYTES(QW/8)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_type(cfg_type), .cfg_unsigned(cfg_unsigned), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_ready(out_ready), .out_valid(out_valid), .err(err),
        .fire(fire), .idle(st_idle), .buf_o(buf_w),
        .type_o(cur_type), .usn_o(cur_usn), .mode_o(cur_mode)
    );

    vux_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_expand (
        .buf_i(buf_w), .fmt(cur_type), .usn(cur_usn), .lanes_o(lanes_w)
    );

    assign add_rows = (cur_mode == MODE_OFFSET) || (cur_mode == MODE_ACCUM);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_sum
        assign out_qw[LANE_W*gi +: LANE_W] = lanes_w[LANE_W*gi +: LANE_W]
            + (add_rows ? row_flat[LANE_W*gi +: LANE_W] : '0);
    end

    vux_rows #(.LANES(LANES), .LANE_W(LANE_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .load(row_load), .load_data(row_wdata),
        .acc_en(fire && (cur_mode == MODE_ACCUM)), .acc_data(out_qw),
        .rows_o(row_flat)
    );

endmodule

// File: rtl/vec_unpack_chk.sv
module vec_unpack_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   cfg_type,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [127:0] out_qw,
    input logic         err,
    input logic         row_load,
    input logic         st_idle,
    input logic [3:0]   cur_type,
    input logic [1:0]   cur_mode,
    input logic [127:0] rows
);
    assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !row_load |=> out_valid && $stable(out_qw));

    assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !in_ready && !out_valid);

    assert_bad_code_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle && in_valid && cfg_type[1:0] == 2'd3 && cfg_type != 4'hF |=> err);

    assert_one_side_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_accum_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && cur_mode == 2'd2 && !row_load |=> rows == $past(out_qw));

    assert_scalar_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cur_type[3:2] == 2'd0 && cur_mode == 2'd0 |->
        out_qw[31:0] == out_qw[63:32] && out_qw[31:0] == out_qw[95:64] &&
        out_qw[31:0] == out_qw[127:96]);
endmodule

bind vec_unpack vec_unpack_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_qw(out_qw), .err(err), .row_load(row_load), .st_idle(st_idle),
    .cur_type(cur_type), .cur_mode(cur_mode), .rows(row_flat)
);

// File: tb/vec_unpack_tb.sv
module vec_unpack_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   cfg_type = '0;
    logic         cfg_unsigned = 1'b0;
    logic [1:0]   cfg_mode = '0;
    logic         row_load = 1'b0;
    logic [127:0] row_wdata = '0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = '0;
    logic         in_ready, out_valid, err;
    logic         out_ready = 1'b0;
    logic [127:0] out_qw;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vec_unpack u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_unsigned(cfg_unsigned),
        .cfg_mode(cfg_mode), .row_load(row_load), .row_wdata(row_wdata),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_qw(out_qw), .err(err)
    );

    typedef struct packed {
        logic [3:0]   t;
        logic         u;
        logic [4:0]   nb;
        logic [127:0] din;
        logic [127:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 1'b0, 5'd4,  128'h12345678, {4{32'h12345678}}},
        '{4'h1, 1'b0, 5'd2,  128'h8034, {4{32'hFFFF8034}}},
        '{4'h1, 1'b1, 5'd2,  128'h8034, {4{32'h00008034}}},
        '{4'h2, 1'b0, 5'd1,  128'hF0, {4{32'hFFFFFFF0}}},
        '{4'h4, 1'b0, 5'd8,  128'h55667788_11223344, 128'h0_55667788_11223344},
        '{4'h5, 1'b0, 5'd4,  128'h8001_7FFF, 128'h0_FFFF8001_00007FFF},
        '{4'hA, 1'b0, 5'd3,  128'hFF8001, 128'h00000000_FFFFFFFF_FFFFFF80_00000001},
        '{4'hA, 1'b1, 5'd3,  128'hFF8001, 128'h00000000_000000FF_00000080_00000001},
        '{4'hC, 1'b0, 5'd16, 128'h44444444_33333333_22222222_11111111,
                             128'h44444444_33333333_22222222_11111111},
        '{4'hD, 1'b1, 5'd8,  128'h8000_0003_0002_0001, 128'h00008000_00000003_00000002_00000001},
        '{4'hE, 1'b0, 5'd4,  128'h807F0201, 128'hFFFFFF80_0000007F_00000002_00000001},
        '{4'h0, 1'b1, 5'd4,  128'h80000000, {4{32'h80000000}}},
        '{4'h0, 1'b0, 5'd4,  128'h80000000, {4{32'h80000000}}},
        '{4'hF, 1'b0, 5'd2,  128'hC03F, 128'h00000080_00000080_00000008_000000F8},
        '{4'hF, 1'b1, 5'd2,  128'hC03F, 128'h00000080_00000080_00000008_000000F8}
    };

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_group(input logic [3:0] t, input logic u, input logic [1:0] m,
                             input logic [4:0] nb, input logic [127:0] din,
                             input int stall, output logic [127:0] got);
        cfg_type = t; cfg_unsigned = u; cfg_mode = m;
        in_valid = 1'b1;
        for (int k = 0; k < int'(nb); k++) begin
            in_byte = din[8*k +: 8];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        got = out_qw;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R11 stall hold", {127'd0, out_valid}, 128'd1);
            check("R11 stall data", out_qw, got);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic load_rows(input logic [127:0] v);
        row_wdata = v; row_load = 1'b1;
        @(negedge clk);
        row_load = 1'b0;
    endtask

    task automatic bad_code(input logic [3:0] t);
        cfg_type = t; in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 err raised", {125'd0, err, in_ready, out_valid}, 128'b100);
        in_valid = 1'b0;
        cfg_type = 4'h0;
        @(negedge clk);
        check("R7 err cleared", {127'd0, err}, 128'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] got;
        repeat (3) @(negedge clk);
        check("R13 reset outputs", {125'd0, in_ready, out_valid, err}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_mode = 2'd1;
        run_group(4'h0, 1'b0, 2'd1, 5'd4, 128'h0, 0, got);
        check("R13 rows zero after reset", got, 128'h0);

        // R1 R2 R3 R4 R5 R6: format table
        for (int i = 0; i < NV; i++) begin
            run_group(VECS[i].t, VECS[i].u, 2'd0, VECS[i].nb, VECS[i].din, 0, got);
            check($sformatf("R1-table entry %0d (R2 R3 R4 R5 R6)", i), got, VECS[i].exp);
        end

        // R7 invalid codes
        bad_code(4'h3);
        bad_code(4'h7);
        bad_code(4'hB);
        run_group(4'h0, 1'b0, 2'd0, 5'd4, 128'h0000BEEF, 0, got);
        check("R7 recovers", got, {4{32'h0000BEEF}});

        // R12 + R8 offset mode, rows unchanged
        load_rows(128'h00000040_00000030_00000020_00000010);
        run_group(4'h0, 1'b0, 2'd1, 5'd4, 128'h5, 0, got);
        check("R8 R12 offset", got, 128'h00000045_00000035_00000025_00000015);
        run_group(4'h0, 1'b0, 2'd1, 5'd4, 128'h5, 0, got);
        check("R8 rows unchanged", got, 128'h00000045_00000035_00000025_00000015);

        // R10 modes 0 and 3 ignore rows
        run_group(4'h0, 1'b0, 2'd0, 5'd4, 128'h5, 0, got);
        check("R10 mode0", got, {4{32'h5}});
        run_group(4'h0, 1'b0, 2'd3, 5'd4, 128'h5, 0, got);
        check("R10 mode3", got, {4{32'h5}});

        // R9 accumulate
        load_rows(128'h00000400_00000300_00000200_00000100);
        run_group(4'h4, 1'b0, 2'd2, 5'd8, 128'h00000002_00000001, 0, got);
        check("R9 accum first", got, 128'h00000400_00000300_00000202_00000101);
        run_group(4'h4, 1'b0, 2'd2, 5'd8, 128'h00000002_00000001, 0, got);
        check("R9 accum second", got, 128'h00000400_00000300_00000204_00000102);
        run_group(4'h0, 1'b0, 2'd1, 5'd4, 128'h0, 0, got);
        check("R9 rows written back", got, 128'h00000400_00000300_00000204_00000102);

        // R11 stall
        run_group(4'hD, 1'b0, 2'd0, 5'd8, 128'hFFFF_0003_8000_0001, 3, got);
        check("R11 stalled data", got, 128'hFFFFFFFF_00000003_FFFF8000_00000001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule